// File: doc/BRIEF.md
# Clock Output Drive-Mode Selector

This block decides how every pin of a clock generator's output bank is driven. The bank has six groups: processor clocks, peripheral-bus clocks (with one free-running pin), memory clocks, a reference clock, a 48 MHz serial-bus clock and graphics-port clocks. A 2-bit function field and a per-pin enable vector control how the pins are driven. The block does not synthesize any frequency. In normal mode each pin passes its group's synthesized clock. In three-state mode every pin floats. In test mode every group is driven from the block clock `clk`, which then carries an externally supplied test clock, through a fixed divide ratio for each group.

A small state machine registers the function field and the frequency-select bit on each rising edge of `clk`. It has three states. MD_NORMAL is entered through the FALLBACK_NORMAL transition, taken when the field is 00 or 10, or when it is 01 with `sel1` high. MD_TEST is entered through ENTER_TEST, taken when the field is 01 with `sel1` low. MD_HIZ is entered through ENTER_HIZ, taken when the field is 11. Reset forces MD_NORMAL. A 2-bit divide counter runs only while in MD_TEST. It is held at zero in every other state, so all divided outputs start together, low, each time test mode is entered.

Top module: `clk_drive_sel`

## Requirements
- R1: With `func_sel` = 11, every bit of `pin_oe` is 0 (high impedance) and `pin_val` is 0, from the first rising edge of `clk` after the field is applied.
- R2: With `func_sel` = 00, every `pin_oe` bit is 1 and each pin carries its group source. Pin layout: [3:0] processor, [8:4] peripheral (bit 8 free-running), [20:9] memory, [21] reference, [22] serial-bus, [24:23] graphics.
- R3: With `func_sel` = 01 and `sel1` = 0 (test mode), the processor, memory, serial-bus and graphics pins toggle every `clk` cycle (clk/2). The peripheral pins change every second cycle (clk/4). The reference pin follows `clk` itself.
- R4: With `func_sel` = 01 and `sel1` = 1, the block stays in normal operation, as in R2.
- R5: A pin whose `pin_en` bit is 0 drives 0 with `pin_oe` = 1, in both normal and test mode.
- R6: With `func_sel` = 10, the block operates exactly as in normal mode (R2).
- R7: On every entry into test mode, all divided pins read 0 in the first cycle. The clk/2 pins read 1 in the second cycle and the clk/4 pins read 1 in the third cycle, whatever count a previous test period left behind.
- R8: A change of `func_sel` or `sel1` takes effect at the next rising edge of `clk`. A synchronous low `rst_n` returns the block to normal mode and clears the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; carries the test clock in test mode |
| rst_n | input | 1 | Synchronous active-low reset |
| func_sel | input | 2 | Function field: 00/10 normal, 01 test, 11 three-state |
| sel1 | input | 1 | Frequency-select bit; high blocks test mode |
| src_cpu | input | 1 | Synthesized processor clock |
| src_pci | input | 1 | Synthesized peripheral-bus clock |
| src_sdram | input | 1 | Synthesized memory clock |
| src_ref | input | 1 | Reference clock |
| src_usb | input | 1 | 48 MHz serial-bus clock |
| src_agp | input | 1 | Synthesized graphics-port clock |
| pin_en | input | 25 | Per-pin enable, same layout as `pin_val` |
| pin_val | output | 25 | Per-pin driven value |
| pin_oe | output | 25 | Per-pin output enable (0 = high impedance) |

## Verification
The sources are driven as static levels with alternating group patterns, so any misrouted group or swapped pin range shows up as a wrong bit. In test mode the sources are held low, so a divided pattern can only come from the test path. The four cycles after entry separate the clk/2 groups from the clk/4 groups, and sampling the reference pin in both clock phases shows it is undivided. The test-mode request is also made with `sel1` high, and test mode is left and re-entered partway through a count, to tell the fallback and the counter restart apart from a free-running divider.

// File: rtl/clk_drive_pkg.sv
package clk_drive_pkg;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'd0,
        MD_TEST   = 2'd1,
        MD_HIZ    = 2'd2
    } drv_mode_e;

    typedef enum logic [1:0] {
        TR_UNDIV = 2'd0,
        TR_DIV2  = 2'd1,
        TR_DIV4  = 2'd2
    } test_ratio_e;

    localparam logic [1:0] FUNC_TEST = 2'b01;
    localparam logic [1:0] FUNC_HIZ  = 2'b11;

endpackage

// File: rtl/clk_drive_fsm.sv
module clk_drive_fsm
    import clk_drive_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] func_sel,
    input  logic       sel1,
    output drv_mode_e  mode
);

    drv_mode_e state_q;
    drv_mode_e state_d;

    always_comb begin
        unique case (func_sel)
            FUNC_HIZ:  state_d = MD_HIZ;                      // ENTER_HIZ
            FUNC_TEST: state_d = sel1 ? MD_NORMAL : MD_TEST;  // ENTER_TEST or fallback
            default:   state_d = MD_NORMAL;                   // FALLBACK_NORMAL
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MD_NORMAL;
        else        state_q <= state_d;
    end

    assign mode = state_q;

    AST_TEST_NEEDS_SEL1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_TEST) |-> ($past(func_sel) == FUNC_TEST && !$past(sel1))); // R4

    AST_HIZ_FROM_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) == FUNC_HIZ) |-> (state_q == MD_HIZ)); // R1

endmodule

// File: rtl/clk_test_div.sv
module clk_test_div #(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_on,
    output logic div2,
    output logic div4
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !test_on) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign div2 = cnt_q[0];
    assign div4 = cnt_q[1];

    AST_DIV_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (test_on && !$past(test_on)) |-> (!div2 && !div4)); // R7

    AST_DIV2_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && test_on && $past(test_on)) |-> (div2 != $past(div2))); // R3

endmodule

// File: rtl/clk_group_mux.sv
module clk_group_mux
    import clk_drive_pkg::*;
#(
    parameter int          WIDTH = 1,
    parameter test_ratio_e RATIO = TR_DIV2
) (
    input  drv_mode_e        mode,
    input  logic             src,
    input  logic             tclk,
    input  logic             div2,
    input  logic             div4,
    input  logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] oe
);

    logic test_bit;

    generate
        if (RATIO == TR_UNDIV) begin : g_undiv
            assign test_bit = tclk;
        end else if (RATIO == TR_DIV4) begin : g_div4
            assign test_bit = div4;
        end else begin : g_div2
            assign test_bit = div2;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MD_HIZ: begin
                val = '0;
                oe  = '0;
            end
            MD_TEST: begin
                val = {WIDTH{test_bit}} & en;
                oe  = '1;
            end
            default: begin
                val = {WIDTH{src}} & en;
                oe  = '1;
            end
        endcase
    end

    always_comb begin
        if (mode != MD_HIZ) begin
            AST_OFF_PIN_LOW: assert ((val & ~en) == '0); // R5
        end
    end

endmodule

// File: rtl/clk_drive_sel.sv
module clk_drive_sel
    import clk_drive_pkg::*;
#(
    parameter int N_CPU   = 4,
    parameter int N_PCI   = 5,
    parameter int N_SDRAM = 12,
    parameter int N_AGP   = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [1:0]                               func_sel,
    input  logic                                     sel1,
    input  logic                                     src_cpu,
    input  logic                                     src_pci,
    input  logic                                     src_sdram,
    input  logic                                     src_ref,
    input  logic                                     src_usb,
    input  logic                                     src_agp,
    input  logic [N_CPU+N_PCI+N_SDRAM+N_AGP+1:0]     pin_en,
    output logic [N_CPU+N_PCI+N_SDRAM+N_AGP+1:0]     pin_val,
    output logic [N_CPU+N_PCI+N_SDRAM+N_AGP+1:0]     pin_oe
);

    localparam int N_PINS  = N_CPU + N_PCI + N_SDRAM + N_AGP + 2;
    localparam int O_CPU   = 0;
    localparam int O_PCI   = O_CPU + N_CPU;
    localparam int O_SDRAM = O_PCI + N_PCI;
    localparam int O_REF   = O_SDRAM + N_SDRAM;
    localparam int O_USB   = O_REF + 1;
    localparam int O_AGP   = O_USB + 1;

    drv_mode_e mode;
    logic      div2;
    logic      div4;

    clk_drive_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .func_sel (func_sel),
        .sel1     (sel1),
        .mode     (mode)
    );

    clk_test_div #(.CNT_W(2)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_on (mode == MD_TEST),
        .div2    (div2),
        .div4    (div4)
    );

    clk_group_mux #(.WIDTH(N_CPU), .RATIO(TR_DIV2)) u_cpu (
        .mode(mode), .src(src_cpu), .tclk(clk), .div2(div2), .div4(div4),
        .en(pin_en[O_CPU +: N_CPU]), .val(pin_val[O_CPU +: N_CPU]), .oe(pin_oe[O_CPU +: N_CPU])
    );

    clk_group_mux #(.WIDTH(N_PCI), .RATIO(TR_DIV4)) u_pci (
        .mode(mode), .src(src_pci), .tclk(clk), .div2(div2), .div4(div4),
        .en(pin_en[O_PCI +: N_PCI]), .val(pin_val[O_PCI +: N_PCI]), .oe(pin_oe[O_PCI +: N_PCI])
    );

    clk_group_mux #(.WIDTH(N_SDRAM), .RATIO(TR_DIV2)) u_sdram (
        .mode(mode), .src(src_sdram), .tclk(clk), .div2(div2), .div4(div4),
        .en(pin_en[O_SDRAM +: N_SDRAM]), .val(pin_val[O_SDRAM +: N_SDRAM]),
        .oe(pin_oe[O_SDRAM +: N_SDRAM])
    );

    clk_group_mux #(.WIDTH(1), .RATIO(TR_UNDIV)) u_ref (
        .mode(mode), .src(src_ref), .tclk(clk), .div2(div2), .div4(div4),
        .en(pin_en[O_REF +: 1]), .val(pin_val[O_REF +: 1]), .oe(pin_oe[O_REF +: 1])
    );

    clk_group_mux #(.WIDTH(1), .RATIO(TR_DIV2)) u_usb (
        .mode(mode), .src(src_usb), .tclk(clk), .div2(div2), .div4(div4),
        .en(pin_en[O_USB +: 1]), .val(pin_val[O_USB +: 1]), .oe(pin_oe[O_USB +: 1])
    );

    clk_group_mux #(.WIDTH(N_AGP), .RATIO(TR_DIV2)) u_agp (
        .mode(mode), .src(src_agp), .tclk(clk), .div2(div2), .div4(div4),
        .en(pin_en[O_AGP +: N_AGP]), .val(pin_val[O_AGP +: N_AGP]), .oe(pin_oe[O_AGP +: N_AGP])
    );

    AST_HIZ_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) == 2'b11) |-> (pin_oe == '0 && pin_val == '0)); // R1

    AST_NORMAL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) != 2'b11) |-> (pin_oe == {N_PINS{1'b1}})); // R2

    AST_SEL1_BLOCKS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_sel) == 2'b01 && $past(sel1))
            |-> (pin_val[O_PCI] == (src_pci & pin_en[O_PCI]))); // R4

endmodule

// File: tb/clk_drive_sel_tb.sv
module clk_drive_sel_tb;

    localparam int NP = 25;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    func_sel;
    logic          sel1;
    logic          s_cpu, s_pci, s_sdram, s_ref, s_usb, s_agp;
    logic [NP-1:0] pin_en;
    logic [NP-1:0] pin_val;
    logic [NP-1:0] pin_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    clk_drive_sel u_dut (
        .clk(clk), .rst_n(rst_n), .func_sel(func_sel), .sel1(sel1),
        .src_cpu(s_cpu), .src_pci(s_pci), .src_sdram(s_sdram),
        .src_ref(s_ref), .src_usb(s_usb), .src_agp(s_agp),
        .pin_en(pin_en), .pin_val(pin_val), .pin_oe(pin_oe)
    );

    function automatic logic [NP-1:0] vec(input logic c, input logic p, input logic s,
                                          input logic r, input logic u, input logic a);
        return {{2{a}}, u, r, {12{s}}, {5{p}}, {4{c}}};
    endfunction

    task automatic chk(input string req, input logic [NP-1:0] ev, input logic [NP-1:0] eo);
        checks++;
        if (pin_val !== ev || pin_oe !== eo) begin
            errors++;
            $display("FAIL %s val=%h oe=%h expected val=%h oe=%h", req, pin_val, pin_oe, ev, eo);
        end
    endtask

    task automatic set_src(input logic c, input logic p, input logic s,
                           input logic r, input logic u, input logic a);
        s_cpu = c; s_pci = p; s_sdram = s; s_ref = r; s_usb = u; s_agp = a;
    endtask

    task automatic step(input logic [1:0] f, input logic s1);
        func_sel = f;
        sel1 = s1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(2'b11, 1'b0);
        step(2'b11, 1'b0);
        chk("R8 reset", '1, '1);
        rst_n = 1'b1;
    endtask

    task automatic t_normal();
        set_src(1, 0, 1, 0, 1, 0);
        step(2'b00, 1'b0);
        chk("R2 pattern a", vec(1, 0, 1, 0, 1, 0), '1);
        set_src(0, 1, 0, 1, 0, 1);
        #0;
        @(negedge clk);
        chk("R2 pattern b", vec(0, 1, 0, 1, 0, 1), '1);
    endtask

    task automatic t_enable();
        set_src(1, 1, 1, 1, 1, 1);
        pin_en = 25'h0A5A5A5;
        @(negedge clk);
        chk("R5 normal", 25'h0A5A5A5, '1);
        pin_en = '1;
    endtask

    task automatic t_func10();
        set_src(1, 0, 0, 1, 1, 0);
        step(2'b10, 1'b0);
        chk("R6", vec(1, 0, 0, 1, 1, 0), '1);
    endtask

    task automatic t_hiz();
        set_src(1, 1, 1, 1, 1, 1);
        func_sel = 2'b11;
        #1;
        chk("R8 not before edge", '1, '1);
        @(negedge clk);
        chk("R1 float", '0, '0);
        @(negedge clk);
        chk("R1 hold", '0, '0);
    endtask

    task automatic t_test();
        set_src(0, 0, 0, 0, 0, 0);
        step(2'b00, 1'b0);
        step(2'b01, 1'b0);
        chk("R3 c0", vec(0, 0, 0, 0, 0, 0), '1);
        @(negedge clk);
        chk("R3 c1", vec(1, 0, 1, 0, 1, 1), '1);
        @(posedge clk);
        #1;
        chk("R3 ref high", vec(0, 1, 0, 1, 0, 0), '1);
        @(negedge clk);
        chk("R3 c2", vec(0, 1, 0, 0, 0, 0), '1);
        @(negedge clk);
        chk("R3 c3", vec(1, 1, 1, 0, 1, 1), '1);
        pin_en = 25'h1F0000F;
        #1;
        chk("R5 test", vec(1, 1, 1, 0, 1, 1) & 25'h1F0000F, '1);
        pin_en = '1;
    endtask

    task automatic t_realign();
        step(2'b00, 1'b0);
        step(2'b01, 1'b0);
        @(negedge clk);
        chk("R7 mid count", vec(1, 0, 1, 0, 1, 1), '1);
        step(2'b00, 1'b0);
        step(2'b01, 1'b0);
        chk("R7 restart c0", vec(0, 0, 0, 0, 0, 0), '1);
        @(negedge clk);
        chk("R7 restart c1", vec(1, 0, 1, 0, 1, 1), '1);
        @(negedge clk);
        chk("R7 restart c2", vec(0, 1, 0, 0, 0, 0), '1);
    endtask

    task automatic t_sel1();
        set_src(1, 0, 1, 1, 0, 1);
        step(2'b01, 1'b1);
        chk("R4 fallback", vec(1, 0, 1, 1, 0, 1), '1);
        @(negedge clk);
        chk("R4 hold", vec(1, 0, 1, 1, 0, 1), '1);
    endtask

    task automatic t_reset_mid();
        set_src(0, 0, 0, 0, 0, 0);
        step(2'b01, 1'b0);
        @(negedge clk);
        set_src(1, 1, 1, 1, 1, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset in test", '1, '1);
        rst_n = 1'b1;
        step(2'b01, 1'b0);
        set_src(0, 0, 0, 0, 0, 0);
        #1;
        chk("R8 divider cleared", vec(0, 0, 0, 0, 0, 0), '1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        func_sel = 2'b00;
        sel1 = 1'b0;
        pin_en = '1;
        set_src(1, 1, 1, 1, 1, 1);
        @(negedge clk);
        t_reset();
        t_normal();
        t_enable();
        t_func10();
        t_hiz();
        t_test();
        t_realign();
        t_sel1();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule